// File: doc/BRIEF.md
# Word-Aligned Load/Store Adapter

This block sits between a core's load/store path and a data memory that is organized as 32-bit words. The memory disregards the two lowest address bits and always returns the whole aligned word. On a load, the adapter works out which bytes of that word the instruction wants and widens them to a full register value. On a store, it presents the aligned address, the data to be written and the write strobe.

The adapter forms the effective address by adding the sign-extended immediate offset to the base register value. The low bits of that sum pick a byte lane or a halfword within the returned word, and the remaining bits form the word address sent to memory. Stores always write a whole word, so there are no byte enables. The adapter relies on the program issuing only aligned accesses and does not check for misalignment.

Top module: `lsw_adapter`

## Requirements
- R1: `mem_addr` equals `base_val` plus `imm_ofs` sign-extended from 12 bits, computed modulo 2^32, with bits 1:0 cleared.
- R2: `mem_we` is 1 exactly when `op_code` is 7'h23 and `op_funct3` is 3'd2.
- R3: `mem_wdata` always carries `store_val` unmodified.
- R4: With `op_funct3` = 3'd0, `load_data[7:0]` is the byte of `mem_rdata` in lane n = effective address bits 1:0, little-endian (lane n occupies bits 8n+7:8n). Bits 31:8 are copies of the selected byte's bit 7.
- R5: With `op_funct3` = 3'd1, `load_data[15:0]` is the low halfword of `mem_rdata` (bits 15:0) when effective address bit 1 is 0, and the high halfword (bits 31:16) when it is 1. Bits 31:16 are copies of the selected halfword's bit 15.
- R6: With `op_funct3` = 3'd2, `load_data` equals `mem_rdata`.
- R7: Any `op_funct3` other than 0, 1 or 2 passes `mem_rdata` to `load_data` unchanged.
- R8: `mem_we` is 0 for every `op_code` other than 7'h23, including loads (7'h03), and for 7'h23 with any `op_funct3` other than 2.
- R9: `load_data` depends only on `op_funct3`, the effective address and `mem_rdata`. It is the same whether or not `op_code` marks a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 7 | Major opcode of the current instruction |
| op_funct3 | input | 3 | Width/kind selector of the current instruction |
| base_val | input | 32 | Base register value |
| imm_ofs | input | 12 | Signed immediate offset |
| store_val | input | 32 | Register value to store |
| mem_rdata | input | 32 | Aligned word returned by memory |
| mem_addr | output | 32 | Word-aligned byte address to memory |
| mem_wdata | output | 32 | Write data to memory |
| mem_we | output | 1 | Memory write strobe |
| load_data | output | 32 | Extracted and extended load result |

## Verification
The lane and extension assertions take for granted that halfword accesses are even and that word accesses are multiples of four. The halfword check therefore looks only at address bit 1 and ignores bit 0. The stimulus keeps every halfword and word access aligned, and it places byte accesses on all four lanes. Negative offsets and an address that wraps past zero are used to reach those lanes through the adder. The read word is chosen so that lanes differ in their top bit, which exercises both positive and negative extension.

// File: rtl/lsw_pkg.sv
// Shared opcode and access-width codes for the load/store adapter.
// Assumes the standard 32-bit base integer instruction encoding.
package lsw_pkg;
    localparam logic [6:0] OPC_LOAD  = 7'h03;
    localparam logic [6:0] OPC_STORE = 7'h23;
    localparam logic [2:0] F3_BYTE   = 3'd0;
    localparam logic [2:0] F3_HALF   = 3'd1;
    localparam logic [2:0] F3_WORD   = 3'd2;
endpackage

// File: rtl/lsw_addr_gen.sv
// Effective-address generator: base plus sign-extended offset.
// Emits the word-aligned address and the in-word lane index.
// Assumes DATA_W is a power-of-two multiple of 8.
module lsw_addr_gen #(
    parameter int DATA_W = 32,
    parameter int OFS_W  = 12,
    localparam int LANES      = DATA_W / 8,
    localparam int LANE_SEL_W = $clog2(LANES)
) (
    input  logic [DATA_W-1:0]     base_i,
    input  logic [OFS_W-1:0]      ofs_i,
    output logic [DATA_W-1:0]     word_addr_o,
    output logic [LANE_SEL_W-1:0] lane_o
);
    logic [DATA_W-1:0] ofs_ext;
    logic [DATA_W-1:0] eff;

    // Widen the offset by replicating its sign bit.
    always_comb ofs_ext = {{(DATA_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};

    // Effective address, wrapping modulo 2^DATA_W.
    always_comb eff = base_i + ofs_ext;

    // Split into aligned word address and lane index.
    always_comb begin
        word_addr_o = {eff[DATA_W-1:LANE_SEL_W], {LANE_SEL_W{1'b0}}};
        lane_o      = eff[LANE_SEL_W-1:0];
    end

    // Guard: the aligned address lies within one word below the effective address.
    always_comb begin
        AST_ADDR_WINDOW: assert ((eff - word_addr_o) < DATA_W'(LANES)) else $error("word address outside window"); // R1
    end
endmodule

// File: rtl/lsw_load_extract.sv
// Load-result former: picks a byte lane or halfword from the aligned
// memory word and sign-extends it; other widths pass the word through.
// Assumes halfword accesses are even (lane bit 0 is ignored for them).
module lsw_load_extract
    import lsw_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES      = DATA_W / 8,
    localparam int HALVES     = LANES / 2,
    localparam int LANE_SEL_W = $clog2(LANES)
) (
    input  logic [2:0]            funct3_i,
    input  logic [LANE_SEL_W-1:0] lane_i,
    input  logic [DATA_W-1:0]     rdata_i,
    output logic [DATA_W-1:0]     data_o
);
    logic [7:0]  lane_byte [LANES];
    logic [15:0] lane_half [HALVES];
    logic [7:0]  byte_pick;
    logic [15:0] half_pick;

    // Little-endian byte lanes of the read word.
    for (genvar g = 0; g < LANES; g++) begin : g_byte
        assign lane_byte[g] = rdata_i[8*g +: 8];
    end

    // Little-endian halfword lanes of the read word.
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign lane_half[h] = rdata_i[16*h +: 16];
    end

    // Choose the addressed byte and halfword.
    always_comb begin
        byte_pick = lane_byte[lane_i];
        half_pick = lane_half[lane_i[LANE_SEL_W-1:1]];
    end

    // Width decode with sign extension; unknown widths pass the word.
    always_comb begin
        case (funct3_i)
            F3_BYTE: data_o = {{(DATA_W-8){byte_pick[7]}}, byte_pick};
            F3_HALF: data_o = {{(DATA_W-16){half_pick[15]}}, half_pick};
            default: data_o = rdata_i;
        endcase
    end

    // Guards relating the result to the raw word at the port.
    always_comb begin
        if (funct3_i == F3_BYTE) begin
            AST_BYTE_LANE: assert (data_o[7:0] == rdata_i[8*lane_i +: 8]) else $error("byte lane wrong"); // R4
            AST_BYTE_FILL: assert (data_o[DATA_W-1:8] == {(DATA_W-8){rdata_i[8*lane_i+7]}}) else $error("byte fill wrong"); // R4
        end
        if (funct3_i == F3_HALF) begin
            AST_HALF_LANE: assert (data_o[15:0] == rdata_i[16*lane_i[LANE_SEL_W-1:1] +: 16]) else $error("half lane wrong"); // R5
            AST_HALF_FILL: assert (data_o[DATA_W-1:16] == {(DATA_W-16){rdata_i[16*lane_i[LANE_SEL_W-1:1]+15]}}) else $error("half fill wrong"); // R5
        end
        if (funct3_i == F3_WORD) begin
            AST_WORD_PASS: assert (data_o == rdata_i) else $error("word not passed"); // R6
        end
        if (funct3_i > F3_WORD) begin
            AST_OTHER_PASS: assert (data_o == rdata_i) else $error("unknown width altered word"); // R7
        end
    end
endmodule

// File: rtl/lsw_store_ctl.sv
// Store control: raises the write strobe for a full-word store only,
// and forwards the register value as write data.
// Assumes stores are word-aligned; no byte enables are produced.
module lsw_store_ctl
    import lsw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [6:0]        opcode_i,
    input  logic [2:0]        funct3_i,
    input  logic [DATA_W-1:0] store_val_i,
    output logic              we_o,
    output logic [DATA_W-1:0] wdata_o
);
    // Strobe decode: word store encoding only.
    always_comb we_o = (opcode_i == OPC_STORE) && (funct3_i == F3_WORD);

    // Write data is the store register value as is.
    always_comb wdata_o = store_val_i;

    // Guard: a strobe implies the store opcode.
    always_comb begin
        AST_WE_NEEDS_STORE: assert (!we_o || opcode_i == OPC_STORE) else $error("strobe without store opcode"); // R2
    end
endmodule

// File: rtl/lsw_adapter.sv
// Word-aligned load/store adapter: address generation, load extraction
// and store control for a memory returning whole aligned words.
// Purely combinational; assumes aligned accesses.
module lsw_adapter
    import lsw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFS_W  = 12,
    localparam int LANE_SEL_W = $clog2(DATA_W / 8)
) (
    input  logic [6:0]        op_code,
    input  logic [2:0]        op_funct3,
    input  logic [DATA_W-1:0] base_val,
    input  logic [OFS_W-1:0]  imm_ofs,
    input  logic [DATA_W-1:0] store_val,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [DATA_W-1:0] load_data
);
    logic [LANE_SEL_W-1:0] lane;

    lsw_addr_gen #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_addr (
        .base_i      (base_val),
        .ofs_i       (imm_ofs),
        .word_addr_o (mem_addr),
        .lane_o      (lane)
    );

    lsw_load_extract #(.DATA_W(DATA_W)) u_load (
        .funct3_i (op_funct3),
        .lane_i   (lane),
        .rdata_i  (mem_rdata),
        .data_o   (load_data)
    );

    lsw_store_ctl #(.DATA_W(DATA_W)) u_store (
        .opcode_i    (op_code),
        .funct3_i    (op_funct3),
        .store_val_i (store_val),
        .we_o        (mem_we),
        .wdata_o     (mem_wdata)
    );

    // Guard at the top: loads never strobe memory, and the address is aligned.
    always_comb begin
        AST_LOAD_NO_WRITE: assert (!(op_code == OPC_LOAD && mem_we)) else $error("load wrote memory"); // R8
        AST_ADDR_ALIGNED: assert (mem_addr[LANE_SEL_W-1:0] == '0) else $error("address not aligned"); // R1
    end
endmodule

// File: tb/sim_lsw_adapter.sv
module sim_lsw_adapter;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic [6:0]  op;
        logic [2:0]  f3;
        logic [31:0] base;
        logic [11:0] ofs;
        logic [31:0] sval;
        logic [31:0] rdata;
        logic [31:0] eaddr;
        logic        ewe;
        logic [31:0] eload;
    } vec_t;

    localparam int NVEC = 17;
    localparam vec_t VECS [NVEC] = '{
        '{7'h03, 3'd0, 32'h0000_1000, 12'h000, 32'h0, 32'h8180_7F01, 32'h0000_1000, 1'b0, 32'h0000_0001},
        '{7'h03, 3'd0, 32'h0000_1000, 12'h001, 32'h0, 32'h8180_7F01, 32'h0000_1000, 1'b0, 32'h0000_007F},
        '{7'h03, 3'd0, 32'h0000_1000, 12'h002, 32'h0, 32'h8180_7F01, 32'h0000_1000, 1'b0, 32'hFFFF_FF80},
        '{7'h03, 3'd0, 32'h0000_1000, 12'h003, 32'h0, 32'h8180_7F01, 32'h0000_1000, 1'b0, 32'hFFFF_FF81},
        '{7'h03, 3'd0, 32'h0000_1004, 12'hFFF, 32'h0, 32'h8180_7F01, 32'h0000_1000, 1'b0, 32'hFFFF_FF81},
        '{7'h03, 3'd1, 32'h0000_2000, 12'h000, 32'h0, 32'h8180_7F01, 32'h0000_2000, 1'b0, 32'h0000_7F01},
        '{7'h03, 3'd1, 32'h0000_2000, 12'h002, 32'h0, 32'h8180_7F01, 32'h0000_2000, 1'b0, 32'hFFFF_8180},
        '{7'h03, 3'd1, 32'h0000_2010, 12'hFF2, 32'h0, 32'h8180_7F01, 32'h0000_2000, 1'b0, 32'hFFFF_8180},
        '{7'h03, 3'd2, 32'h0000_3000, 12'h008, 32'h0, 32'h8180_7F01, 32'h0000_3008, 1'b0, 32'h8180_7F01},
        '{7'h03, 3'd4, 32'h0000_3000, 12'h001, 32'h0, 32'h8180_7F01, 32'h0000_3000, 1'b0, 32'h8180_7F01},
        '{7'h23, 3'd2, 32'h0000_4000, 12'h7FC, 32'hDEAD_BEEF, 32'h8180_7F01, 32'h0000_47FC, 1'b1, 32'h8180_7F01},
        '{7'h23, 3'd2, 32'h0000_4000, 12'h800, 32'h1357_9BDF, 32'h0000_0000, 32'h0000_3800, 1'b1, 32'h0000_0000},
        '{7'h13, 3'd2, 32'h0000_0010, 12'h004, 32'hCAFE_0001, 32'h5555_AAAA, 32'h0000_0014, 1'b0, 32'h5555_AAAA},
        '{7'h23, 3'd0, 32'h0000_0020, 12'h000, 32'h0000_00FF, 32'h0000_0000, 32'h0000_0020, 1'b0, 32'h0000_0000},
        '{7'h03, 3'd0, 32'h0000_0050, 12'h002, 32'h0, 32'h1234_5678, 32'h0000_0050, 1'b0, 32'h0000_0034},
        '{7'h03, 3'd1, 32'h0000_0050, 12'h002, 32'h0, 32'h1234_5678, 32'h0000_0050, 1'b0, 32'h0000_1234},
        '{7'h03, 3'd1, 32'h0000_0060, 12'h000, 32'h0, 32'h0000_8000, 32'h0000_0060, 1'b0, 32'hFFFF_8000}
    };

    logic        clk = 1'b0;
    logic [6:0]  op_code;
    logic [2:0]  op_funct3;
    logic [31:0] base_val;
    logic [11:0] imm_ofs;
    logic [31:0] store_val;
    logic [31:0] mem_rdata;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_we;
    logic [31:0] load_data;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;

    lsw_adapter u0 (
        .op_code   (op_code),
        .op_funct3 (op_funct3),
        .base_val  (base_val),
        .imm_ofs   (imm_ofs),
        .store_val (store_val),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .load_data (load_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [6:0] op, input logic [2:0] f3, input logic [31:0] b,
                         input logic [11:0] o, input logic [31:0] sv, input logic [31:0] rd);
        @(posedge clk);
        op_code = op; op_funct3 = f3; base_val = b; imm_ofs = o; store_val = sv; mem_rdata = rd;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", WATCHDOG, WATCHDOG);
        finish_run();
    end

    initial begin
        op_code = '0; op_funct3 = '0; base_val = '0; imm_ofs = '0; store_val = '0; mem_rdata = '0;
        @(negedge clk);
        // Idle state with all inputs at zero: no write, zero address (R1, R8).
        check("R8", "idle we", {31'b0, mem_we}, 32'h0);
        check("R1", "idle addr", mem_addr, 32'h0);

        // Vector table: address (R1), strobe (R2/R8), wdata (R3), load result (R4..R7).
        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i].op, VECS[i].f3, VECS[i].base, VECS[i].ofs, VECS[i].sval, VECS[i].rdata);
            check("R1", $sformatf("vec%0d addr", i), mem_addr, VECS[i].eaddr);
            check(VECS[i].ewe ? "R2" : "R8", $sformatf("vec%0d we", i), {31'b0, mem_we}, {31'b0, VECS[i].ewe});
            check("R3", $sformatf("vec%0d wdata", i), mem_wdata, VECS[i].sval);
            check(VECS[i].f3 == 3'd0 ? "R4" : VECS[i].f3 == 3'd1 ? "R5" : VECS[i].f3 == 3'd2 ? "R6" : "R7",
                  $sformatf("vec%0d load", i), load_data, VECS[i].eload);
        end

        // R1: address wraps past zero.
        drive(7'h03, 3'd2, 32'hFFFF_FFFC, 12'h004, 32'h0, 32'h0BAD_F00D);
        check("R1", "wrap addr", mem_addr, 32'h0000_0000);

        // R9: byte extraction ignores the opcode (non-load opcode, lane 3).
        drive(7'h33, 3'd0, 32'h0000_0103, 12'h000, 32'h0, 32'hF011_2233);
        check("R9", "load_data under non-load opcode", load_data, 32'hFFFF_FFF0);
        check("R8", "no strobe for 7'h33", {31'b0, mem_we}, 32'h0);

        // R7: highest unknown width code passes the word.
        drive(7'h03, 3'd7, 32'h0000_0001, 12'h000, 32'h0, 32'h8000_0080);
        check("R7", "funct3=7 pass", load_data, 32'h8000_0080);

        // R3: a store with changing read data keeps the write data and strobe.
        drive(7'h23, 3'd2, 32'h0000_0100, 12'h000, 32'hA5A5_5A5A, 32'hFFFF_FFFF);
        check("R3", "wdata under store", mem_wdata, 32'hA5A5_5A5A);
        check("R2", "strobe under store", {31'b0, mem_we}, 32'h1);

        // R2: store opcode with halfword width does not strobe.
        drive(7'h23, 3'd1, 32'h0000_0100, 12'h000, 32'hA5A5_5A5A, 32'h0);
        check("R2", "no strobe for funct3=1 store", {31'b0, mem_we}, 32'h0);

        finish_run();
    end
endmodule